// File: doc/BRIEF.md
# Pulse-swallow dual-modulus frequency divider

This block divides a fast input clock by a ratio taken from a parallel, hard-wired program word. Internally it is built the way high-speed synthesiser dividers are: a prescaler that counts either 8 or 9 input cycles per output tick, a small swallow counter that decides how many of those ticks use the longer modulus, and a main counter that sets how many prescaler ticks make up one whole division cycle. The total ratio is therefore eight times the main count plus the swallow count.

The program word is level sensitive and has no load strobe. The block samples it only at the boundary between two division cycles, so a word that changes mid-cycle affects only the next cycle. Every division cycle ends with one output pulse that stays high for exactly one short prescaler period, which is 8 input cycles. A synchronous active-high reset clears all counters. The first cycle then starts on the first clock edge after reset.

Top module: `pulse_swallow_div`

## Requirements
- R1: The input-clock count between consecutive rising edges of `div_out` equals 8·M + A. A is `prog[2:0]` and M is `prog[13:3]`, both as unsigned values, with M ≥ A.
- R2: Inside a division cycle the prescaler ends A periods of 9 input cycles first. The remaining M − A periods are 8 cycles each, so every prescaler period lasts 8 or 9 cycles.
- R3: The extreme legal ratios divide exactly. 56 uses M=7, A=0, and 16383 uses M=2047, A=7.
- R4: Each `div_out` pulse is high for exactly 8 consecutive input clock cycles.
- R5: `prog` is sampled only on the clock edge that ends a division cycle. A change during a cycle, even one reverted before the boundary, leaves that cycle's length unchanged. The new word sets the length of the following cycle.
- R6: `div_out` is low while `rst` is high and on the edge after any reset. After release the first edge starts a division cycle, and the first pulse rises on the edge that ends it, R = 8·M + A edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| prog | input | 14 | Program word: swallow count in bits 2..0, main count in bits 13..3 |
| div_out | output | 1 | Divided output, one 8-cycle pulse per division cycle |

## Verification
The bench uses the default build: an 8/9 prescaler (3-bit swallow field) and an 11-bit main count. This brings both ends of the legal range within reach, 56 and 16383, along with mid-range words that have zero, partial and full swallow counts. It also times changes of the program word against the cycle boundary and applies a reset in the middle of a pulse. The prescaler period is observed inside the block, so R2 is checked on every tick and not only through the total ratio.

// File: rtl/pd_pkg.sv
package pd_pkg;
    // Default geometry: prescaler base modulus 2**PS_LOG2, main count width M_W
    localparam int DEF_PS_LOG2 = 3;
    localparam int DEF_M_W     = 11;

    // Ratio produced by a given main/swallow pair
    function automatic int unsigned div_ratio(input int unsigned m_cnt,
                                              input int unsigned a_cnt,
                                              input int unsigned ps_log2);
        return (m_cnt << ps_log2) + a_cnt;
    endfunction
endpackage

// File: rtl/pd_prescaler.sv
module pd_prescaler #(
    parameter int PS_LOG2 = pd_pkg::DEF_PS_LOG2
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_mod,   // next period uses base modulus + 1
    output logic tick      // last input cycle of a prescaler period
);
    localparam int NBASE = 1 << PS_LOG2;
    localparam int CW    = PS_LOG2 + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;

    assign tick = (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.cnt = hi_mod ? CW'(NBASE) : CW'(NBASE - 1);
        end else begin
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/pd_swallow.sv
module pd_swallow #(
    parameter int PS_LOG2 = pd_pkg::DEF_PS_LOG2,
    parameter int M_W     = pd_pkg::DEF_M_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [PS_LOG2-1:0] prog_a,
    input  logic [M_W-1:0]     prog_m,
    output logic               hi_mod,
    output logic               wrap     // division cycle ends on this edge
);
    typedef struct packed {
        logic [PS_LOG2-1:0] a;
        logic [M_W-1:0]     m;
    } sw_state_t;

    sw_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        wrap = tick && (s_q.m <= M_W'(1));
        if (tick) begin
            if (wrap) begin
                s_d.a = prog_a;
                s_d.m = prog_m;
            end else begin
                s_d.m = s_q.m - M_W'(1);
                s_d.a = (s_q.a != '0) ? s_q.a - PS_LOG2'(1) : '0;
            end
        end
        hi_mod = (s_d.a != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/pd_pulse.sv
module pd_pulse #(
    parameter int PS_LOG2 = pd_pkg::DEF_PS_LOG2
) (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    output logic pulse
);
    localparam int NBASE = 1 << PS_LOG2;

    typedef struct packed {
        logic               run;
        logic               out;
        logic [PS_LOG2-1:0] left;
    } pw_state_t;

    pw_state_t s_d, s_q;

    assign pulse = s_q.out;

    always_comb begin
        s_d     = s_q;
        s_d.run = 1'b1;
        if (wrap && s_q.run) begin
            s_d.out  = 1'b1;
            s_d.left = PS_LOG2'(NBASE - 1);
        end else if (s_q.out) begin
            if (s_q.left == '0) s_d.out  = 1'b0;
            else                s_d.left = s_q.left - PS_LOG2'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
    parameter int PS_LOG2 = pd_pkg::DEF_PS_LOG2,
    parameter int M_W     = pd_pkg::DEF_M_W,
    localparam int PROG_W = M_W + PS_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PROG_W-1:0] prog,
    output logic              div_out
);
    logic pre_tick;
    logic hi_mod;
    logic wrap;

    pd_prescaler #(.PS_LOG2(PS_LOG2)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .hi_mod (hi_mod),
        .tick   (pre_tick)
    );

    pd_swallow #(.PS_LOG2(PS_LOG2), .M_W(M_W)) u_sw (
        .clk    (clk),
        .rst    (rst),
        .tick   (pre_tick),
        .prog_a (prog[PS_LOG2-1:0]),
        .prog_m (prog[PROG_W-1:PS_LOG2]),
        .hi_mod (hi_mod),
        .wrap   (wrap)
    );

    pd_pulse #(.PS_LOG2(PS_LOG2)) u_pw (
        .clk   (clk),
        .rst   (rst),
        .wrap  (wrap),
        .pulse (div_out)
    );
endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
    parameter int PS_LOG2 = pd_pkg::DEF_PS_LOG2,
    parameter int M_W     = pd_pkg::DEF_M_W
) (
    input logic clk,
    input logic rst,
    input logic div_out,
    input logic tick
);
    localparam int NBASE = 1 << PS_LOG2;
    localparam int GW    = M_W + PS_LOG2 + 2;
    localparam int MINR  = NBASE * (NBASE - 1);
    localparam int MAXR  = ((1 << M_W) - 1) * NBASE + NBASE - 1;

    logic          out_prev;
    logic [7:0]    hi_len;
    logic [7:0]    tgap;
    logic          tseen;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_prev <= 1'b0;
            hi_len   <= '0;
            tgap     <= '0;
            tseen    <= 1'b0;
            gap      <= '0;
        end else begin
            out_prev <= div_out;
            hi_len   <= div_out ? hi_len + 8'd1 : 8'd0;
            tgap     <= tick ? 8'd1 : tgap + 8'd1;
            if (tick) tseen <= 1'b1;
            if (div_out && !out_prev) gap <= GW'(1);
            else if (gap != {GW{1'b1}}) gap <= gap + GW'(1);
        end
    end

    // R4: a pulse that ends lasted exactly one short prescaler period
    a_r4_pulse_width: assert property (@(posedge clk) disable iff (rst)
        (out_prev && !div_out) |-> (hi_len == 8'(NBASE)));

    // R2: every prescaler period is the base modulus or one more
    a_r2_prescale_mod: assert property (@(posedge clk) disable iff (rst)
        (tick && tseen) |-> (tgap == 8'(NBASE) || tgap == 8'(NBASE + 1)));

    // R3: spacing of rising edges stays inside the legal ratio range
    a_r3_ratio_range: assert property (@(posedge clk) disable iff (rst)
        (div_out && !out_prev) |-> (gap >= GW'(MINR) && gap <= GW'(MAXR + 1)));

    // R6: output is low on the edge after a reset
    a_r6_reset_low: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !div_out);
endmodule

bind pulse_swallow_div pd_checker #(.PS_LOG2(PS_LOG2), .M_W(M_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .div_out (div_out),
    .tick    (pre_tick)
);

// File: tb/pulse_swallow_div_test.sv
module pulse_swallow_div_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 199000;
    localparam int NV         = 7;
    // {M, A, expected ratio, pulses to measure}
    localparam int TBL [NV][4] = '{
        '{7,    0, 56,    20},
        '{7,    7, 63,    20},
        '{8,    3, 67,    20},
        '{12,   1, 97,    20},
        '{50,   5, 405,   20},
        '{154,  2, 1234,  20},
        '{2047, 7, 16383, 6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] prog = '0;
    logic        div_out;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    pulse_swallow_div uut (
        .clk     (clk),
        .rst     (rst),
        .prog    (prog),
        .div_out (div_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [13:0] word(input int m, input int a);
        return {m[10:0], a[2:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(output int c);
        logic p;
        p = div_out;
        @(negedge clk);
        while (!(div_out && !p)) begin
            p = div_out;
            @(negedge clk);
        end
        c = cyc;
    endtask

    task automatic wait_fall(output int c);
        @(negedge clk);
        while (div_out) @(negedge clk);
        c = cyc;
    endtask

    // Reset, load a word, release; returns counter value before first active edge
    task automatic restart(input logic [13:0] w, output int rel);
        @(negedge clk);
        rst  = 1'b1;
        prog = w;
        repeat (2) @(negedge clk);
        rel = cyc;
        rst = 1'b0;
    endtask

    task automatic measure(input int m, input int a, input int ratio, input int npulse);
        int rel, c0, c1, f;
        string rq;
        rq = (ratio == 56 || ratio == 16383) ? "R3" : "R1";
        restart(word(m, a), rel);
        wait_rise(c0);
        check((c0 - rel - 1) == ratio, "R6 first pulse", c0 - rel - 1, ratio);
        for (int k = 1; k < npulse; k++) begin
            wait_fall(f);
            check((f - c0) == 8, "R4 width", f - c0, 8);
            wait_rise(c1);
            // period also exercises the 9/8 prescaler split (R2)
            check((c1 - c0) == ratio, rq, c1 - c0, ratio);
            c0 = c1;
        end
        wait_fall(f);
        check((f - c0) == 8, "R4 width", f - c0, 8);
    endtask

    initial begin
        int rel, c0, c1;
        // reset state
        repeat (3) @(negedge clk);
        check(div_out == 1'b0, "R6 reset low", int'(div_out), 0);

        // table of legal words
        for (int i = 0; i < NV; i++) begin
            check(pd_pkg::div_ratio(TBL[i][0], TBL[i][1], 3) == TBL[i][2], "R1 table",
                  pd_pkg::div_ratio(TBL[i][0], TBL[i][1], 3), TBL[i][2]);
            measure(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3]);
        end

        // R5: word change right after a boundary applies one cycle later
        restart(word(7, 0), rel);
        wait_rise(c0);
        prog = word(10, 2);
        wait_rise(c1);
        check((c1 - c0) == 56, "R5 old word kept", c1 - c0, 56);
        c0 = c1;
        wait_rise(c1);
        check((c1 - c0) == 82, "R5 new word", c1 - c0, 82);
        c0 = c1;
        // R5: glitch reverted before the boundary is ignored
        repeat (30) @(negedge clk);
        prog = word(20, 0);
        repeat (10) @(negedge clk);
        prog = word(10, 2);
        wait_rise(c1);
        check((c1 - c0) == 82, "R5 glitch ignored", c1 - c0, 82);

        // R6: reset in the middle of a pulse drops the output at once
        repeat (3) @(negedge clk);
        check(div_out == 1'b1, "R4 mid pulse high", int'(div_out), 1);
        rst = 1'b1;
        @(negedge clk);
        check(div_out == 1'b0, "R6 reset mid pulse", int'(div_out), 0);
        rst = 1'b0;
        rel = cyc;
        wait_rise(c0);
        check((c0 - rel - 1) == 82, "R6 restart delay", c0 - rel - 1, 82);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule